// File: doc/BRIEF.md
# Real-Time Seconds Timer

This block is a free-running up-counter driven by a slow time base. A programmable divider turns a stream of slow-clock pulses into a periodic tick, and every tick advances a 32-bit count. Programming the divider with the slow-clock frequency gives a count in seconds. Software cannot load the count. It can only restart it, which clears both the count and the divider phase.

The slow time base reaches the block as a one-cycle enable, `slow_en`, that is synchronous to the bus clock `clk`. Any crossing out of the slow clock domain happens before this block. The count is updated on `clk`, so a value read twice may still differ if a tick lands between the reads.

Software uses four word registers on a simple register bus. A write takes effect on the clock edge at which `bus_req` and `bus_we` are high. Read data is combinational from `bus_addr` and is valid in the same cycle as the read request. The read side effect takes place at the closing edge of that cycle. There is no data stream at the block's edge, so no back-pressure applies. Two event flags are kept: an alarm match and a tick. Each flag can drive the single level interrupt through its own enable.

Top module: `rtsec_timer`

## Requirements
- R1: After reset, the control word (byte offset 0x00) reads 0x00008000: divider 0x8000 and both enables off. The alarm word (0x04) reads 0xFFFFFFFF. The count (0x08) and the flags (0x0C) read 0, and `irq` is low.
- R2: Register decode uses `bus_addr[3:2]`: 0x00 control, 0x04 alarm, 0x08 count, 0x0C flags. Writes to 0x08 and 0x0C have no effect on any register.
- R3: Control bits 15:0 hold the divider N. The count grows by 1 on every N-th `slow_en` pulse. N = 0 acts as 65536.
- R4: Writing 1 to control bit 18 clears the count and the divider phase in that cycle. The next increment comes after a full N pulses. Bit 18 is not stored and always reads 0.
- R5: Every tick sets the increment flag, flags bit 1.
- R6: The tick at which the count becomes equal to the alarm word sets the alarm flag, flags bit 0.
- R7: A read at 0x0C returns the flags and clears them. A flag that is set in the same cycle as that read remains set for the next read.
- R8: `irq` is high exactly when (flags bit 0 AND control bit 16) OR (flags bit 1 AND control bit 17).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_en | input | 1 | One pulse per slow-clock period |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench tries to get an extra increment or a missing increment right after a restart. It also tries the divider value 0, where a naive divider would stall or tick on every pulse. It times a flags read to fall on the same edge as a tick: a design that clears without regard for the new event would drop that tick's flag. Writes to the read-only count and flags words are checked as well, along with the gating of `irq` by each enable, since a crossed enable bit would raise the wrong interrupt.

// File: rtl/rtsec_pkg.sv
package rtsec_pkg;
  localparam int CNT_W = 32;
  localparam int PRE_W = 16;
  localparam logic [1:0] W_CTRL  = 2'd0;
  localparam logic [1:0] W_ALARM = 2'd1;
  localparam logic [1:0] W_COUNT = 2'd2;
  localparam logic [1:0] W_FLAGS = 2'd3;
  localparam int B_ALM_IE  = 16;
  localparam int B_INC_IE  = 17;
  localparam int B_RESTART = 18;
  localparam int F_ALM = 0;
  localparam int F_INC = 1;
endpackage

// File: rtl/rtsec_prescaler.sv
module rtsec_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_en,
  input  logic             restart,
  input  logic [PRE_W-1:0] divisor,
  output logic             tick
);
  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] last;

  // divisor 0 wraps to all ones: a 2^PRE_W period
  assign last = divisor - 1'b1;
  assign tick = slow_en && (phase == last) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase <= '0;
    else if (slow_en)      phase <= (phase == last) ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/rtsec_counter.sv
module rtsec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] count,
  output logic             alarm_hit
);
  logic [CNT_W-1:0] next_count;

  assign next_count = count + 1'b1;
  assign alarm_hit  = tick && (next_count == alarm);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) count <= '0;
    else if (tick)         count <= next_count;
  end
endmodule

// File: rtl/rtsec_status.sv
module rtsec_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] set_ev,
  input  logic       rd_clr,
  output logic [1:0] flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (rd_clr ? 2'b00 : flags) | set_ev;
  end
endmodule

// File: rtl/rtsec_timer.sv
module rtsec_timer
  import rtsec_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter logic [PRE_W-1:0] RESET_DIV = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_en,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [PRE_W-1:0] divisor;
  logic             alm_ie, inc_ie;
  logic [CNT_W-1:0] alarm, count;
  logic             tick, alarm_hit, restart;
  logic [1:0]       flags;
  logic [1:0]       word;
  logic             wr, rd;

  assign word    = bus_addr[3:2];
  assign wr      = bus_req && bus_we;
  assign rd      = bus_req && !bus_we;
  assign restart = wr && (word == W_CTRL) && bus_wdata[B_RESTART];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divisor <= RESET_DIV;
      alm_ie  <= 1'b0;
      inc_ie  <= 1'b0;
      alarm   <= '1;
    end else if (wr) begin
      if (word == W_CTRL) begin
        divisor <= bus_wdata[PRE_W-1:0];
        alm_ie  <= bus_wdata[B_ALM_IE];
        inc_ie  <= bus_wdata[B_INC_IE];
      end
      if (word == W_ALARM) alarm <= bus_wdata[CNT_W-1:0];
    end
  end

  rtsec_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .restart(restart),
    .divisor(divisor), .tick(tick)
  );

  rtsec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
    .alarm(alarm), .count(count), .alarm_hit(alarm_hit)
  );

  rtsec_status u_sts (
    .clk(clk), .rst_n(rst_n),
    .set_ev({tick, alarm_hit}),
    .rd_clr(rd && (word == W_FLAGS)),
    .flags(flags)
  );

  always_comb begin
    bus_rdata = '0;
    case (word)
      W_CTRL: begin
        bus_rdata[PRE_W-1:0] = divisor;
        bus_rdata[B_ALM_IE]  = alm_ie;
        bus_rdata[B_INC_IE]  = inc_ie;
      end
      W_ALARM: bus_rdata[CNT_W-1:0] = alarm;
      W_COUNT: bus_rdata[CNT_W-1:0] = count;
      default: bus_rdata[1:0] = flags;
    endcase
  end

  assign irq = (flags[F_ALM] && alm_ie) || (flags[F_INC] && inc_ie);
endmodule

// File: rtl/rtsec_timer_chk.sv
module rtsec_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        restart,
  input logic        rd_flags,
  input logic [31:0] count,
  input logic [1:0]  flags,
  input logic        alm_ie,
  input logic        inc_ie,
  input logic        irq
);
  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (count != $past(count)) |-> (count == $past(count) + 32'd1 || count == 32'd0));

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (!tick && !restart) |=> $stable(count));

  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == 32'd0));

  assert_tick_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flags[1]);

  assert_alarm_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $rose(flags[0]) |-> $past(tick));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && !tick) |=> (flags == 2'b00));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!alm_ie && !inc_ie) |-> !irq);
endmodule

bind rtsec_timer rtsec_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
  .rd_flags(rd && (word == 2'd3)), .count(count), .flags(flags),
  .alm_ie(alm_ie), .inc_ie(inc_ie), .irq(irq)
);

// File: tb/test_rtsec_timer.sv
module test_rtsec_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_en = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  rtsec_timer i_rtsec_timer (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: compares every read against the scoreboard
  always @(negedge clk) begin
    if (bus_req && !bus_we) begin
      logic [31:0] e;
      string t;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s: unexpected read, got %h expected none", "R2", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t,
                    input logic with_slow = 1'b0);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; slow_en = with_slow;
    @(posedge clk); #1;
    bus_req = 1'b0; slow_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic pulses(input int n);
    @(posedge clk); #1;
    slow_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 slow_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq=%b expected %b", t, irq, e);
    end
  endtask

  initial begin
    fork
      begin
        repeat (180000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(4'h0, 32'h0000_8000, "R1");
    rd(4'h4, 32'hFFFF_FFFF, "R1");
    rd(4'h8, 32'h0, "R1");
    rd(4'hC, 32'h0, "R1");

    // R4 restart with divider 3; R3 increment after 3 pulses
    wr(4'h0, 32'h0004_0003);
    pulses(2);
    rd(4'h8, 32'd0, "R4");
    pulses(1);
    rd(4'h8, 32'd1, "R3");
    rd(4'h0, 32'h0000_0003, "R4");      // restart bit reads 0
    rd(4'hC, 32'd2, "R5");
    rd(4'hC, 32'd0, "R7");

    // R6 alarm at count 3
    wr(4'h4, 32'd3);
    pulses(6);
    rd(4'h8, 32'd3, "R6");
    chk_irq(1'b0, "R8");
    wr(4'h0, 32'h0001_0003);             // alarm enable
    chk_irq(1'b1, "R8");
    rd(4'hC, 32'd3, "R6");
    chk_irq(1'b0, "R8");
    wr(4'h0, 32'h0002_0003);             // increment enable only
    pulses(3);
    chk_irq(1'b1, "R8");
    rd(4'hC, 32'd2, "R6");               // no alarm at count 4
    chk_irq(1'b0, "R8");

    // R2 read-only words
    wr(4'h8, 32'h0000_1234);
    rd(4'h8, 32'd4, "R2");
    wr(4'hC, 32'h3);
    rd(4'hC, 32'd0, "R2");
    rd(4'h4, 32'd3, "R2");

    // R4 restart clears count
    wr(4'h0, 32'h0004_0003);
    rd(4'h8, 32'd0, "R4");

    // R7 tick on the same edge as a flags read
    wr(4'h0, 32'h0004_0001);
    rd(4'hC, 32'd0, "R7", 1'b1);
    rd(4'hC, 32'd2, "R7");
    rd(4'h8, 32'd1, "R7");

    // R3 divider 0 means 65536
    wr(4'h0, 32'h0004_0000);
    pulses(65535);
    rd(4'h8, 32'd0, "R3");
    pulses(1);
    rd(4'h8, 32'd1, "R3");

    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule